// File: doc/BRIEF.md
# Modulo Address Generation Unit

This unit produces data-memory and table-memory addresses for a fixed-point signal processor. It holds four general pointer registers. Each has its own base, length and increment register. A fifth pointer, with its own increment, is reserved for coefficient table lookups. Two access ports, one for reads and one for writes, can each select any of the four general pointers in a cycle. The selected pointer's current value is presented as the address, and the pointer is then post-modified: it holds, steps up by one, steps down by one, or adds its increment register.

When circular mode is requested and a pointer's length register is nonzero, the pointer stays inside the buffer that starts at its base and holds that many words. The base may sit at any address and the length need not be a power of two. When a step runs past the buffer's last word, the pointer re-enters at the base plus the overshoot. A step down from the base lands on the last word. Software sets up a buffer by writing the length and the base. Each of those writes also parks the pointer at the base.

Top module: `modulo_agu`

## Requirements
- R1: After reset every pointer, base, length and increment register, and both table registers, read as zero, so all three address outputs are 0.
- R2: `rd_addr` and `wr_addr` always show the current value of the pointer named by `rd_sel` and `wr_sel` in the same cycle, before any modification. Either port may name any of the four pointers.
- R3: Post-modify codes are 0 hold, 1 plus one, 2 minus one and 3 plus the pointer's increment register. The new value is visible from the next cycle. With `circ_en` low the arithmetic wraps modulo 512.
- R4: With `circ_en` high and a nonzero length L, a step that takes the pointer past base+L-1 yields base plus the overshoot, that is, the sum minus L. This holds for steps no larger than L.
- R5: With `circ_en` high and a nonzero length, a minus-one step taken at the base yields base+L-1.
- R6: A pointer whose length register is zero steps linearly even when `circ_en` is high.
- R7: When both ports name the same pointer in one cycle, the read-port modification is applied first and the write-port modification is applied to its result. Both addresses show the value from before the cycle.
- R8: Load field codes are 0 pointer, 1 base, 2 length and 3 increment. A base load sets the pointer to the new base. A length load sets the pointer to the current base. A pointer, base or length load takes priority over any modification of that pointer in the same cycle.
- R9: `tbl_addr` is the 11-bit table pointer. It uses the same post-modify codes with its own increment and wraps modulo 2048. A table load (field 0 pointer, 1 increment) takes priority over a table modification in the same cycle.
- R10: A port whose request is low leaves its selected pointer unchanged, whatever modify code it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req | input | 1 | Read port access request |
| rd_sel | input | 2 | Pointer used by the read port |
| rd_mod | input | 2 | Read port post-modify code |
| wr_req | input | 1 | Write port access request |
| wr_sel | input | 2 | Pointer used by the write port |
| wr_mod | input | 2 | Write port post-modify code |
| circ_en | input | 1 | Circular addressing for both ports this cycle |
| ld_en | input | 1 | Load strobe for a general pointer's registers |
| ld_sel | input | 2 | Pointer whose register is loaded |
| ld_field | input | 2 | Which register is loaded |
| ld_data | input | 9 | Load value |
| tbl_req | input | 1 | Table access request |
| tbl_mod | input | 2 | Table post-modify code |
| tbl_ld_en | input | 1 | Table register load strobe |
| tbl_ld_field | input | 1 | 0 loads the table pointer, 1 its increment |
| tbl_ld_data | input | 11 | Table load value |
| rd_addr | output | 9 | Read address to data RAM |
| wr_addr | output | 9 | Write address to data RAM |
| tbl_addr | output | 11 | Address to table ROM |

## Verification
The wrap assertion assumes the pointer already lies in its buffer, that base plus length does not pass the top of the 512-word space, and that the increment does not exceed the length. Outside those conditions the block's result is defined arithmetically but is no longer a buffer member. The random stimulus loads bases below 448 and lengths and increments up to 64, so every buffer fits in memory. Pointer loads for buffered registers fall inside the current buffer. Linear steps can still leave a buffer, and the assertion premise then simply goes false. The bench model follows the same arithmetic, so those cases are still compared.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    PM_HOLD = 2'd0,
    PM_INC1 = 2'd1,
    PM_DEC1 = 2'd2,
    PM_ADD  = 2'd3
  } pmod_e;

  typedef enum logic [1:0] {
    LF_PTR  = 2'd0,
    LF_BASE = 2'd1,
    LF_LEN  = 2'd2,
    LF_STEP = 2'd3
  } ldf_e;
endpackage

// File: rtl/agu_step.sv
module agu_step
  import agu_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] inc,
  input  pmod_e         mode,
  input  logic          circ,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 1;

  logic          wrap_on;
  logic [EW-1:0] top;
  logic [EW-1:0] sum;
  logic [EW-1:0] sum_wrap;
  logic [AW-1:0] amt;

  always_comb begin
    wrap_on  = circ && (len != '0);
    top      = {1'b0, base} + {1'b0, len} - EW'(1);
    amt      = (mode == PM_INC1) ? AW'(1) : inc;
    sum      = {1'b0, ptr} + {1'b0, amt};
    sum_wrap = sum - {1'b0, len};
    nxt      = ptr;
    case (mode)
      PM_HOLD: nxt = ptr;
      PM_INC1, PM_ADD: begin
        if (wrap_on && (sum > top)) nxt = sum_wrap[AW-1:0];
        else                        nxt = sum[AW-1:0];
      end
      PM_DEC1: begin
        if (wrap_on && (ptr == base)) nxt = top[AW-1:0];
        else                          nxt = ptr - AW'(1);
      end
      default: nxt = ptr;
    endcase
  end
endmodule

// File: rtl/agu_slot.sv
module agu_slot
  import agu_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hit,
  input  pmod_e         rd_mod,
  input  logic          wr_hit,
  input  pmod_e         wr_mod,
  input  logic          circ,
  input  logic          ld_hit,
  input  ldf_e          ld_field,
  input  logic [AW-1:0] ld_data,
  output logic [AW-1:0] ptr_q
);
  localparam int EW = AW + 1;

  logic [AW-1:0] base_q, len_q, inc_q;
  logic [AW-1:0] ptr_d, base_d, len_d, inc_d;
  logic [AW-1:0] s1_nxt, s2_nxt, after_rd, after_wr;
  logic          ptr_en, base_en, len_en, inc_en;

  agu_step #(.AW(AW)) u_step_rd (
    .ptr(ptr_q), .base(base_q), .len(len_q), .inc(inc_q),
    .mode(rd_mod), .circ(circ), .nxt(s1_nxt)
  );

  agu_step #(.AW(AW)) u_step_wr (
    .ptr(after_rd), .base(base_q), .len(len_q), .inc(inc_q),
    .mode(wr_mod), .circ(circ), .nxt(s2_nxt)
  );

  always_comb begin
    after_rd = rd_hit ? s1_nxt : ptr_q;
    after_wr = wr_hit ? s2_nxt : after_rd;
    ptr_d    = after_wr;
    base_d   = ld_data;
    len_d    = ld_data;
    inc_d    = ld_data;
    base_en  = ld_hit && (ld_field == LF_BASE);
    len_en   = ld_hit && (ld_field == LF_LEN);
    inc_en   = ld_hit && (ld_field == LF_STEP);
    ptr_en   = rd_hit || wr_hit || (ld_hit && (ld_field != LF_STEP));
    if (ld_hit) begin
      case (ld_field)
        LF_PTR:  ptr_d = ld_data;
        LF_BASE: ptr_d = ld_data;
        LF_LEN:  ptr_d = base_q;
        default: ptr_d = after_wr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      inc_q  <= '0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (base_en) base_q <= base_d;
      if (len_en)  len_q  <= len_d;
      if (inc_en)  inc_q  <= inc_d;
    end
  end

  // buffer membership, used only by the checks below
  logic [EW-1:0] buf_end;
  logic          in_buf, buf_fits;
  assign buf_end  = {1'b0, base_q} + {1'b0, len_q};
  assign in_buf   = (len_q != '0) && (ptr_q >= base_q) && ({1'b0, ptr_q} < buf_end);
  assign buf_fits = buf_end <= (EW'(1) << AW);

  a_r4_stays_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (in_buf && buf_fits && circ && (rd_hit || wr_hit) && !ld_hit && (inc_q <= len_q))
      |=> in_buf);

  a_r5_dec_wraps_to_top: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit && !ld_hit && (rd_mod == PM_DEC1) && circ &&
     (len_q != '0) && (ptr_q == base_q))
      |=> (ptr_q == AW'($past(base_q) + $past(len_q) - AW'(1))));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit || wr_hit || ld_hit) |=> $stable(ptr_q));

  a_r8_base_load_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit && (ld_field == LF_BASE)) |=> (ptr_q == base_q));

  a_r3_linear_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit && !ld_hit && (rd_mod == PM_INC1) && !circ)
      |=> (ptr_q == AW'($past(ptr_q) + AW'(1))));
endmodule

// File: rtl/agu_table.sv
module agu_table
  import agu_pkg::*;
#(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  pmod_e         mode,
  input  logic          ld_en,
  input  logic          ld_field,
  input  logic [TW-1:0] ld_data,
  output logic [TW-1:0] ptr_q
);
  logic [TW-1:0] inc_q, ptr_d, mod_val;
  logic          ptr_en, inc_en;

  always_comb begin
    case (mode)
      PM_INC1: mod_val = ptr_q + TW'(1);
      PM_DEC1: mod_val = ptr_q - TW'(1);
      PM_ADD:  mod_val = ptr_q + inc_q;
      default: mod_val = ptr_q;
    endcase
    inc_en = ld_en && ld_field;
    ptr_en = req || (ld_en && !ld_field);
    ptr_d  = (ld_en && !ld_field) ? ld_data : mod_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inc_q <= '0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (inc_en) inc_q <= ld_data;
    end
  end

  a_r9_tbl_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_field) |=> (ptr_q == $past(ld_data)));

  a_r9_tbl_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(req || ld_en) |=> $stable(ptr_q));
endmodule

// File: rtl/modulo_agu.sv
module modulo_agu
  import agu_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 9,
  parameter int TW   = 11,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [SW-1:0] rd_sel,
  input  logic [1:0]    rd_mod,
  input  logic          wr_req,
  input  logic [SW-1:0] wr_sel,
  input  logic [1:0]    wr_mod,
  input  logic          circ_en,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [1:0]    ld_field,
  input  logic [AW-1:0] ld_data,
  input  logic          tbl_req,
  input  logic [1:0]    tbl_mod,
  input  logic          tbl_ld_en,
  input  logic          tbl_ld_field,
  input  logic [TW-1:0] tbl_ld_data,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [TW-1:0] tbl_addr
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] ptr_arr [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
    logic rd_hit, wr_hit, ld_hit;
    assign rd_hit = rd_req && (rd_sel == SW'(gi));
    assign wr_hit = wr_req && (wr_sel == SW'(gi));
    assign ld_hit = ld_en  && (ld_sel == SW'(gi));

    agu_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .rd_hit   (rd_hit),
      .rd_mod   (pmod_e'(rd_mod)),
      .wr_hit   (wr_hit),
      .wr_mod   (pmod_e'(wr_mod)),
      .circ     (circ_en),
      .ld_hit   (ld_hit),
      .ld_field (ldf_e'(ld_field)),
      .ld_data  (ld_data),
      .ptr_q    (ptr_arr[gi])
    );
  end

  agu_table #(.TW(TW)) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (tbl_req),
    .mode     (pmod_e'(tbl_mod)),
    .ld_en    (tbl_ld_en),
    .ld_field (tbl_ld_field),
    .ld_data  (tbl_ld_data),
    .ptr_q    (tbl_addr)
  );

  assign rd_addr = ptr_arr[rd_sel];
  assign wr_addr = ptr_arr[wr_sel];

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_int_n |=> (tbl_addr == '0));
endmodule

// File: tb/modulo_agu_tb_top.sv
module modulo_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req, wr_req, circ_en, ld_en, tbl_req, tbl_ld_en, tbl_ld_field;
  logic [1:0]  rd_sel, wr_sel, rd_mod, wr_mod, ld_sel, ld_field, tbl_mod;
  logic [8:0]  ld_data;
  logic [10:0] tbl_ld_data;
  logic [8:0]  rd_addr, wr_addr;
  logic [10:0] tbl_addr;

  int unsigned m_ptr [4];
  int unsigned m_base[4];
  int unsigned m_len [4];
  int unsigned m_inc [4];
  int unsigned t_ptr, t_inc;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  modulo_agu dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_mod(rd_mod),
    .wr_req(wr_req), .wr_sel(wr_sel), .wr_mod(wr_mod),
    .circ_en(circ_en),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_field(ld_field), .ld_data(ld_data),
    .tbl_req(tbl_req), .tbl_mod(tbl_mod), .tbl_ld_en(tbl_ld_en),
    .tbl_ld_field(tbl_ld_field), .tbl_ld_data(tbl_ld_data),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .tbl_addr(tbl_addr)
  );

  function automatic int unsigned nstep(int unsigned p, int unsigned b, int unsigned l,
                                        int unsigned s, int m, bit c, int unsigned mask);
    int unsigned n;
    bit wrap;
    wrap = c && (l != 0);
    case (m)
      1, 3: begin
        n = p + ((m == 1) ? 1 : s);
        if (wrap && (n > b + l - 1)) n = n - l;
      end
      2: begin
        if (wrap && (p == b)) n = b + l - 1;
        else n = p + mask;
      end
      default: n = p;
    endcase
    return n & mask;
  endfunction

  task automatic chk(string tag, int unsigned got, int unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    rd_req = 0; wr_req = 0; ld_en = 0; tbl_req = 0; tbl_ld_en = 0;
    rd_mod = 0; wr_mod = 0; tbl_mod = 0; circ_en = 0;
    ld_field = 0; ld_data = 0; tbl_ld_field = 0; tbl_ld_data = 0;
  endtask

  // compare outputs against the model, then clock once and advance the model
  task automatic run(string tag);
    #1;
    chk({tag, " rd_addr"}, rd_addr, m_ptr[rd_sel]);
    chk({tag, " wr_addr"}, wr_addr, m_ptr[wr_sel]);
    chk({tag, " tbl_addr"}, tbl_addr, t_ptr);
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      int unsigned p;
      p = m_ptr[i];
      if (rd_req && rd_sel == i) p = nstep(p, m_base[i], m_len[i], m_inc[i], rd_mod, circ_en, 511);
      if (wr_req && wr_sel == i) p = nstep(p, m_base[i], m_len[i], m_inc[i], wr_mod, circ_en, 511);
      if (ld_en && ld_sel == i) begin
        case (ld_field)
          0: p = ld_data;
          1: begin m_base[i] = ld_data; p = ld_data; end
          2: begin m_len[i] = ld_data; p = m_base[i]; end
          default: m_inc[i] = ld_data;
        endcase
      end
      m_ptr[i] = p;
    end
    if (tbl_ld_en && !tbl_ld_field) t_ptr = tbl_ld_data;
    else if (tbl_req) t_ptr = nstep(t_ptr, 0, 0, t_inc, tbl_mod, 0, 2047);
    if (tbl_ld_en && tbl_ld_field) t_inc = tbl_ld_data;
    @(negedge clk);
  endtask

  task automatic load(int sel, int field, int val, string tag);
    idle();
    ld_en = 1; ld_sel = 2'(sel); rd_sel = 2'(sel); wr_sel = 2'(sel);
    ld_field = 2'(field); ld_data = 9'(val);
    run(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin
      m_ptr[i] = 0; m_base[i] = 0; m_len[i] = 0; m_inc[i] = 0;
    end
    t_ptr = 0; t_inc = 0;
    idle(); rd_sel = 0; wr_sel = 0; ld_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state on every pointer
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i); wr_sel = 2'(3 - i);
      #1;
      chk("R1 rd_addr", rd_addr, 0);
      chk("R1 wr_addr", wr_addr, 0);
      chk("R1 tbl_addr", tbl_addr, 0);
      @(negedge clk);
    end

    // R8: length then base load park the pointer at the base
    load(1, 2, 10, "R8");
    load(1, 1, 100, "R8");
    #1 chk("R8 base load parks ptr", rd_addr, 100);
    load(1, 3, 3, "R8");

    // R4 with R2: walk by the increment and wrap past the top of the buffer
    idle(); circ_en = 1; rd_req = 1; rd_sel = 1; rd_mod = 3; wr_sel = 1;
    for (int k = 0; k < 4; k++) begin
      #1 chk("R2 pre-modify address", rd_addr, 100 + 3 * k);
      run("R4");
    end
    #1 chk("R4 wrap to base plus excess", rd_addr, 102);

    // R5: step down from the base lands on the top word
    load(1, 0, 100, "R8");
    idle(); circ_en = 1; rd_req = 1; rd_sel = 1; rd_mod = 2;
    run("R5");
    #1 chk("R5 dec wrap", rd_addr, 109);

    // R6: zero length stays linear
    load(2, 1, 5, "R8");
    load(2, 2, 0, "R8");
    idle(); circ_en = 1; rd_req = 1; rd_sel = 2; rd_mod = 2;
    run("R6"); run("R6");
    #1 chk("R6 linear with zero length", rd_addr, 3);

    // R7: both ports on one pointer, read first then write
    idle(); circ_en = 1; rd_req = 1; wr_req = 1; rd_sel = 1; wr_sel = 1;
    rd_mod = 3; wr_mod = 1;
    #1 chk("R7 write port pre-value", wr_addr, 109);
    run("R7");
    #1 chk("R7 chained modification", rd_addr, 103);

    // R8: load wins over modification in the same cycle
    idle(); rd_req = 1; rd_sel = 1; rd_mod = 1; ld_en = 1; ld_sel = 1; ld_field = 0; ld_data = 50;
    run("R8");
    #1 chk("R8 load priority", rd_addr, 50);

    // R10: request low ignores the modify code
    idle(); rd_req = 0; rd_sel = 1; rd_mod = 1; wr_req = 0; wr_sel = 1; wr_mod = 3;
    run("R10"); run("R10");
    #1 chk("R10 no request no change", rd_addr, 50);

    // R3: linear wrap at the top of the data space
    load(3, 0, 511, "R8");
    idle(); rd_req = 1; rd_sel = 3; rd_mod = 1;
    run("R3");
    #1 chk("R3 linear wrap", rd_addr, 0);

    // R9: table pointer wraps, steps by its increment, load wins
    idle(); tbl_ld_en = 1; tbl_ld_field = 0; tbl_ld_data = 2047; run("R9");
    idle(); tbl_req = 1; tbl_mod = 1; run("R9");
    #1 chk("R9 table wrap", tbl_addr, 0);
    idle(); tbl_ld_en = 1; tbl_ld_field = 1; tbl_ld_data = 5; run("R9");
    idle(); tbl_req = 1; tbl_mod = 3; run("R9");
    #1 chk("R9 table add", tbl_addr, 5);
    idle(); tbl_req = 1; tbl_mod = 1; tbl_ld_en = 1; tbl_ld_field = 0; tbl_ld_data = 700; run("R9");
    #1 chk("R9 table load priority", tbl_addr, 700);

    // R3: random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      idle();
      rd_req = ($urandom % 10) < 7; rd_sel = 2'($urandom); rd_mod = 2'($urandom);
      wr_req = ($urandom % 10) < 5; wr_sel = 2'($urandom); wr_mod = 2'($urandom);
      circ_en = ($urandom % 10) < 7;
      ld_en = ($urandom % 10) == 0; ld_sel = 2'($urandom); ld_field = 2'($urandom);
      case (ld_field)
        0: ld_data = (m_len[ld_sel] != 0) ? 9'(m_base[ld_sel] + $urandom % m_len[ld_sel])
                                          : 9'($urandom);
        1: ld_data = 9'($urandom % 448);
        default: ld_data = 9'($urandom % 65);
      endcase
      tbl_req = $urandom % 2; tbl_mod = 2'($urandom);
      tbl_ld_en = ($urandom % 20) == 0; tbl_ld_field = 1'($urandom);
      tbl_ld_data = 11'($urandom);
      run("R3");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule